// File: doc/BRIEF.md
# Clock-Stretching Wait-State Generator

This block produces the phase clock for a processor that multiplexes the top byte of its 24-bit address onto the data bus. It works from a free-running source clock and an active-low ready request. A wait state is never made by pulling the processor's own ready pin. That pin may be driven low by the processor itself while it sleeps waiting for an interrupt, so it is left on a pull-up. Instead, the block holds the high half of the phase clock for as many whole source periods as the ready request asks for.

The address byte for bits 23..16 is only valid on the data bus while the phase clock is low. The block therefore drives an enable for the bank-address latch from the phase clock and also keeps its own copy of the latched byte. The enable stays inactive for the whole of a stretch, so that bus contents seen during the wait are never taken as a bank address.

Everything is modelled synchronously on a fast sampling clock. The sampling clock oversamples the source clock, the ready request and the data bus through a chain of synchronizer stages of equal length. The hold decision is made only while the sampled source clock is high. A parameter chooses between two capture styles:
- a transparent latch that follows the bus while the phase clock is low;
- a latch that takes the last low-phase sample at the moment the phase clock rises.

`rst_n` is asserted asynchronously and must be released in step with `clk`.

Top module: `phase_stretch`

## Requirements
- R1: While `rst_n` is low, `phi_o`, `bank_le_o` and `bank_q_o` are all 0 and the hold state is clear; the synchronizer stages reset to source clock 0, ready 1, data 0.
- R2: Source clock, ready and data pass through SYNC_STAGES sampling registers each, so the outputs after `clk` edge k reflect the three inputs as present at edge k-SYNC_STAGES, all with the same delay.
- R3: While no stretch is held, `phi_o` equals the delayed source clock.
- R4: A sampled ready of 0 while the sampled source clock is 1 sets the hold state, and `phi_o` is 1 from that sample onward.
- R5: While the sampled source clock is 0 the hold state does not change, so ready changes confined to a low half neither start nor end a stretch.
- R6: The hold state clears only when the sampled source clock and ready are both 1. A ready of 0 held across N falling source edges keeps `phi_o` high for one high half plus N full source periods; a ready pulse that returns to 1 within the same high half causes no stretch.
- R7: `phi_o` never shows a low interval shorter than the low half of the source clock, including at the entry into and exit from a stretch.
- R8: `bank_le_o` is 1 exactly while `phi_o` is 0, and it is 0 on every sample of a stretch.
- R9: With CAP_MODE = CAP_TRACK, `bank_q_o` takes the aligned data on every sample in which `phi_o` is 0, and it does not change while `phi_o` is 1.
- R10: With CAP_MODE = CAP_CLOSE, `bank_q_o` changes only on the sample where `phi_o` rises. It takes the aligned data of the last sample in which `phi_o` was 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, much faster than the source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_clk_i | input | 1 | Free-running source clock for the processor |
| ready_i | input | 1 | Ready request, 0 asks for a wait state |
| data_i | input | DATA_W | Processor data bus carrying the bank byte in the low phase |
| phi_o | output | 1 | Stretched phase clock for the processor |
| bank_le_o | output | 1 | Enable for the external bank-address latch, active high |
| bank_q_o | output | DATA_W | Latched bank address byte |

## Verification
The bench builds two copies of the block side by side with DATA_W = 8 and SYNC_STAGES = 2, one in each capture mode. Both copies receive the same stimulus, so the two latch styles can be compared against the same phase clock. The source half-periods vary at random between two and six samples, and the ready request toggles on any sample. This places ready changes at every position relative to the source edges, including the very sample of a rise or fall. Directed sequences measure the high-run lengths for zero-, one- and two-period stretches, and for ready pulses confined to a low half or to part of a high half.

// File: rtl/phase_stretch_pkg.sv
`timescale 1ns/1ps
package phase_stretch_pkg;

  // How the bank byte copy is captured.
  typedef enum logic {
    CAP_TRACK = 1'b0,  // follow the bus while the phase clock is low
    CAP_CLOSE = 1'b1   // take the last low-phase sample when the phase clock rises
  } cap_mode_e;

  // Next hold state: decided only while the source clock is high.
  function automatic logic hold_step(input logic src_hi, input logic ready, input logic held);
    if (src_hi) begin
      return !ready;
    end
    return held;
  endfunction

endpackage

// File: rtl/ps_sync.sv
`timescale 1ns/1ps
module ps_sync #(
  parameter int unsigned      W       = 1,
  parameter int unsigned      STAGES  = 2,
  parameter logic [W-1:0]     RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stg[0] <= RST_VAL;
        end else begin
          stg[0] <= d;
        end
      end
    end else begin : g_tail
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stg[i] <= RST_VAL;
        end else begin
          stg[i] <= stg[i-1];
        end
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/ps_hold_ctrl.sv
`timescale 1ns/1ps
module ps_hold_ctrl
  import phase_stretch_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic src_hi,   // sampled source clock
  input  logic ready,    // sampled ready request
  output logic phi_d,    // next phase clock value
  output logic phi_q,    // registered phase clock
  output logic le_q,     // registered latch enable
  output logic hold_q    // stretch in progress
);

  logic hold_d;
  logic le_d;
  logic hold_en;

  // Next-state logic. The phase clock uses the next hold value so that a
  // stretch that starts on this sample never lets a low sample through.
  always_comb begin
    hold_en = src_hi;
    hold_d  = hold_step(src_hi, ready, hold_q);
    phi_d   = src_hi | hold_d;
    le_d    = !phi_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
    end else if (hold_en) begin
      hold_q <= hold_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phi_q <= 1'b0;
      le_q  <= 1'b0;
    end else begin
      phi_q <= phi_d;
      le_q  <= le_d;
    end
  end

endmodule

// File: rtl/ps_bank_latch.sv
`timescale 1ns/1ps
module ps_bank_latch
  import phase_stretch_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter cap_mode_e   CAP_MODE = CAP_TRACK
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phi_d,
  input  logic              phi_q,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] bank_q
);

  logic [DATA_W-1:0] data_q;   // aligned with phi_q
  logic              cap_en;
  logic [DATA_W-1:0] cap_val;

  always_comb begin
    if (CAP_MODE == CAP_CLOSE) begin
      cap_en  = !phi_q && phi_d;   // phase clock about to rise
      cap_val = data_q;            // last sample of the low phase
    end else begin
      cap_en  = !phi_d;            // transparent while the phase clock is low
      cap_val = data_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else begin
      data_q <= data_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
    end else if (cap_en) begin
      bank_q <= cap_val;
    end
  end

endmodule

// File: rtl/phase_stretch.sv
`timescale 1ns/1ps
module phase_stretch
  import phase_stretch_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter cap_mode_e   CAP_MODE    = CAP_TRACK
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_clk_i,
  input  logic              ready_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              phi_o,
  output logic              bank_le_o,
  output logic [DATA_W-1:0] bank_q_o
);

  localparam int unsigned SW = DATA_W + 2;
  localparam logic [SW-1:0] SYNC_RST = {1'b0, 1'b1, {DATA_W{1'b0}}};

  logic [SW-1:0]     raw_bus;
  logic [SW-1:0]     smp_bus;
  logic              src_s;
  logic              ready_s;
  logic [DATA_W-1:0] data_s;
  logic              phi_d;
  logic              phi_q;
  logic              le_q;
  logic              hold_q;

  assign raw_bus = {src_clk_i, ready_i, data_i};

  ps_sync #(
    .W       (SW),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (SYNC_RST)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_bus),
    .q     (smp_bus)
  );

  assign src_s   = smp_bus[SW-1];
  assign ready_s = smp_bus[SW-2];
  assign data_s  = smp_bus[DATA_W-1:0];

  ps_hold_ctrl u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .src_hi (src_s),
    .ready  (ready_s),
    .phi_d  (phi_d),
    .phi_q  (phi_q),
    .le_q   (le_q),
    .hold_q (hold_q)
  );

  ps_bank_latch #(
    .DATA_W   (DATA_W),
    .CAP_MODE (CAP_MODE)
  ) u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .phi_d   (phi_d),
    .phi_q   (phi_q),
    .data_in (data_s),
    .bank_q  (bank_q_o)
  );

  assign phi_o     = phi_q;
  assign bank_le_o = le_q;

endmodule

// File: rtl/phase_stretch_chk.sv
`timescale 1ns/1ps
module phase_stretch_chk
  import phase_stretch_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter cap_mode_e   CAP_MODE = CAP_TRACK
) (
  input logic              clk,
  input logic              rst_n,
  input logic              src_hi,
  input logic              ready,
  input logic              hold,
  input logic              phi,
  input logic              le,
  input logic [DATA_W-1:0] bank
);

  assert_hold_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (src_hi && !ready) |=> (hold && phi));

  assert_hold_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (src_hi && ready) |=> !hold);

  assert_low_half_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !src_hi |=> $stable(hold));

  assert_follow_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_hi && !hold) |=> !phi);

  assert_enable_off_in_stretch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !le);

  if (CAP_MODE == CAP_CLOSE) begin : g_close
    assert_capture_on_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(bank) |-> $rose(phi));
  end else begin : g_track
    assert_capture_when_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(bank) |-> !phi);
  end

endmodule

bind phase_stretch phase_stretch_chk #(
  .DATA_W   (DATA_W),
  .CAP_MODE (CAP_MODE)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .src_hi (src_s),
  .ready  (ready_s),
  .hold   (hold_q),
  .phi    (phi_o),
  .le     (bank_le_o),
  .bank   (bank_q_o)
);

// File: tb/phase_stretch_bench.sv
`timescale 1ns/1ps
module phase_stretch_bench;
  import phase_stretch_pkg::*;

  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          src_clk;
  logic          ready;
  logic [DW-1:0] data;
  logic          phi0, le0, phi1, le1;
  logic [DW-1:0] b0, b1;

  always #2.5 clk = ~clk;

  phase_stretch #(.DATA_W(DW), .SYNC_STAGES(2), .CAP_MODE(CAP_TRACK)) u_phase_stretch (
    .clk(clk), .rst_n(rst_n), .src_clk_i(src_clk), .ready_i(ready), .data_i(data),
    .phi_o(phi0), .bank_le_o(le0), .bank_q_o(b0));

  phase_stretch #(.DATA_W(DW), .SYNC_STAGES(2), .CAP_MODE(CAP_CLOSE)) u_phase_stretch_cl (
    .clk(clk), .rst_n(rst_n), .src_clk_i(src_clk), .ready_i(ready), .data_i(data),
    .phi_o(phi1), .bank_le_o(le1), .bank_q_o(b1));

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // reference state
  logic          p1c, p1r, p2c, p2r;
  logic [DW-1:0] p1d, p2d;
  logic          m_hold, m_phi, m_le;
  logic [DW-1:0] m_dq, m_b0, m_b1;

  // run-length bookkeeping
  int  hi_run = 0;
  int  lo_run = 0;
  bit  rec = 0;
  int  runs [16];
  int  nruns = 0;
  logic rr = 1'b1;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    p1c = 1'b0; p1r = 1'b1; p1d = '0;
    p2c = 1'b0; p2r = 1'b1; p2d = '0;
    m_hold = 1'b0; m_phi = 1'b0; m_le = 1'b0;
    m_dq = '0; m_b0 = '0; m_b1 = '0;
  endtask

  function automatic logic next_hold(input logic c, input logic r, input logic h);
    if (c && !r) return 1'b1;   // R4
    if (c && r)  return 1'b0;   // R6
    return h;                   // R5
  endfunction

  task automatic model_step();
    logic hn, pn;
    if (!rst_n) begin
      model_reset();
    end else begin
      hn = next_hold(p2c, p2r, m_hold);
      pn = p2c | hn;
      if (!pn) m_b0 = p2d;
      if (!m_phi && pn) m_b1 = m_dq;
      m_le   = !pn;
      m_phi  = pn;
      m_dq   = p2d;
      m_hold = hn;
      p2c = p1c; p2r = p1r; p2d = p1d;
      p1c = src_clk; p1r = ready; p1d = data;
    end
  endtask

  task automatic check_outputs();
    chk(phi0 === m_phi, m_hold ? "R4" : "R3", "phi track", int'(phi0), int'(m_phi));
    chk(phi1 === m_phi, "R2", "phi close", int'(phi1), int'(m_phi));
    chk(le0 === m_le, "R8", "enable track", int'(le0), int'(m_le));
    chk(le1 === m_le, "R8", "enable close", int'(le1), int'(m_le));
    chk(b0 === m_b0, "R9", "bank track", int'(b0), int'(m_b0));
    chk(b1 === m_b1, "R10", "bank close", int'(b1), int'(m_b1));
    if (phi0 === 1'b1) begin
      if (lo_run > 0) chk(lo_run >= 2, "R7", "low interval", lo_run, 2);
      lo_run = 0;
      hi_run++;
    end else begin
      if (hi_run > 0 && rec && nruns < 16) begin
        runs[nruns] = hi_run;
        nruns++;
      end
      hi_run = 0;
      lo_run++;
    end
  endtask

  task automatic tick(input logic c, input logic r);
    src_clk = c;
    ready   = r;
    data    = DW'($urandom);
    @(posedge clk);
    model_step();
    @(negedge clk);
    check_outputs();
  endtask

  task automatic half(input logic c, input int len, input logic ra, input logic rb);
    for (int i = 0; i < len; i++) tick(c, (i < len / 2) ? ra : rb);
  endtask

  task automatic rhalf(input logic c, input int len);
    for (int i = 0; i < len; i++) begin
      if ($urandom % 6 == 0) rr = !rr;
      tick(c, rr);
    end
  endtask

  task automatic check_reset_zero();
    chk(phi0 === 1'b0 && phi1 === 1'b0, "R1", "phi in reset", int'(phi0), 0);
    chk(le0 === 1'b0 && le1 === 1'b0, "R1", "enable in reset", int'(le0), 0);
    chk(b0 === '0 && b1 === '0, "R1", "bank in reset", int'(b0), 0);
  endtask

  task automatic random_phase(input int halves);
    for (int h = 0; h < halves; h++) rhalf(h[0], 2 + int'($urandom % 5));
  endtask

  initial begin
    int exp_runs [5];
    string exp_tag [5];
    void'($urandom(32'h1F2E_3D4C));
    rst_n = 1'b0; src_clk = 1'b0; ready = 1'b1; data = '0;
    model_reset();
    repeat (3) @(negedge clk);
    check_reset_zero();
    rst_n = 1'b1;

    // directed: stretch lengths with half-period of 4 samples
    rec = 1;
    half(1'b0, 4, 1'b1, 1'b1); half(1'b1, 4, 1'b1, 1'b1);              // 4
    half(1'b0, 4, 1'b1, 1'b1); half(1'b1, 4, 1'b1, 1'b0);              // 12
    half(1'b0, 4, 1'b0, 1'b1); half(1'b1, 4, 1'b1, 1'b1);
    half(1'b0, 4, 1'b1, 1'b1); half(1'b1, 4, 1'b1, 1'b0);              // 20
    half(1'b0, 4, 1'b0, 1'b0); half(1'b1, 4, 1'b0, 1'b0);
    half(1'b0, 4, 1'b0, 1'b0); half(1'b1, 4, 1'b1, 1'b1);
    half(1'b0, 4, 1'b0, 1'b1); half(1'b1, 4, 1'b1, 1'b1);              // 4
    half(1'b0, 4, 1'b1, 1'b1); half(1'b1, 4, 1'b0, 1'b1);              // 4
    half(1'b0, 4, 1'b1, 1'b1); half(1'b0, 4, 1'b1, 1'b1);
    rec = 0;
    exp_runs = '{4, 12, 20, 4, 4};
    exp_tag  = '{"R3", "R4", "R6", "R5", "R6"};
    chk(nruns >= 5, "R6", "directed run count", nruns, 5);
    for (int i = 0; i < 5; i++) chk(runs[i] == exp_runs[i], exp_tag[i], "high run length", runs[i], exp_runs[i]);

    // random phase
    random_phase(1500);

    // reset in mid-run, asserted asynchronously
    rst_n = 1'b0;
    #1;
    check_reset_zero();
    for (int i = 0; i < 4; i++) tick(i[0], 1'b0);
    rst_n = 1'b1;
    random_phase(1500);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #750000;
    if (!done) begin
      n_bad++;
      $display("FAIL R2 watchdog: actual %0d expected %0d", 150000, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule